// File: doc/BRIEF.md
# Snoop Data Intervention Controller

This block sits on the bus side of a snooping cache attached to a split-transaction bus that can forward lines from one cache to another. It watches address tenures issued by other masters. It gets the coherency state of the snooped line from an external lookup that answers in the same cycle. It then decides whether to claim the transfer by raising a hit indication. After a claim it returns the whole cache line to the requester in a data-only tenure. The data is tagged with the requester's transaction tag, and the first beat is the double-word named by the address.

Whether a transfer can be claimed depends on three things: the transaction type, the transfer size and the write-through and cache-inhibit attributes. On top of that, each cache level has its own class enables for modified, exclusive and shared-responder lines. Data never moves while the address retry window is open. A retry seen inside the window withdraws the claim. When forwarding starts, the block issues a single state write-back for the line.

Top module: `snoop_intervene`

## Requirements
- R1: A claim is made only for transaction type code 0 (read) or 1 (read-with-intent-to-modify). Codes 2 and 3 never raise `hit_o`.
- R2: A claim is made only when `snp_full_i` is 1, which marks a full cache-line transfer.
- R3: A claim is never made when `snp_wt_i` or `snp_ci_i` is 1.
- R4: The line state codes are 0 invalid, 1 shared, 2 exclusive, 3 modified and 4 shared-responder. The level configuration is `l2_cfg_i` when `lk_in_l2_i` is 1 and `l1_cfg_i` otherwise. In that configuration, bit 0 enables intervention and is enough for modified lines. Exclusive lines also need bit 1, and shared-responder lines also need bit 2. Codes 0 and 1 are never claimed.
- R5: `hit_o` is high for exactly RETRY_LAT cycles, starting the cycle after the snoop is sampled.
- R6: If `retry_i` is high in any cycle where `hit_o` is high, `hit_o` falls in the next cycle and no data and no state write-back follow. `retry_i` has no effect outside the window.
- R7: After an unretried window, `drdy_o` is high for four consecutive cycles starting the cycle after the last hit cycle. `dtag_o` carries the tag captured with the snoop.
- R8: The beat index `rd_dw_o` starts at the low two bits of the snooped double-word address and increments modulo 4 on each beat. `rd_line_o` holds the upper address bits. `dbeat_o` carries `rd_data_i` during beats and is zero otherwise.
- R9: `coh_we_o` pulses only on the first beat. `coh_state_o` is 1 (shared) after a read and 0 (invalid) after a read-with-intent-to-modify.
- R10: Snoops that arrive while a claim or a transfer is in progress are not claimed, so `hit_o` stays low once the transfer ends.
- R11: After reset, `hit_o`, `drdy_o`, `coh_we_o` and `dbeat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid_i | input | 1 | Snooped address tenure present |
| snp_dwaddr_i | input | DWA_W | Double-word address of the snooped access |
| snp_ttype_i | input | 2 | Transaction type code |
| snp_full_i | input | 1 | Full cache-line transfer |
| snp_wt_i | input | 1 | Write-through attribute |
| snp_ci_i | input | 1 | Caching-inhibited attribute |
| snp_tag_i | input | TAG_W | Requester transaction tag |
| lk_state_i | input | 3 | Line state returned by the lookup for the snooped address |
| lk_in_l2_i | input | 1 | Line is held in the second-level cache |
| l1_cfg_i | input | 3 | First-level intervention class enables |
| l2_cfg_i | input | 3 | Second-level intervention class enables |
| retry_i | input | 1 | Address retry observed |
| hit_o | output | 1 | Claim of the snooped transfer |
| drdy_o | output | 1 | Data beat valid |
| dtag_o | output | TAG_W | Tag of the data-only tenure |
| dbeat_o | output | DATA_W | Data beat |
| rd_line_o | output | DWA_W-2 | Line address for the cache data read |
| rd_dw_o | output | 2 | Double-word index for the cache data read |
| rd_data_i | input | DATA_W | Cache read data for `rd_line_o`/`rd_dw_o` |
| coh_we_o | output | 1 | Coherency state write-back strobe |
| coh_state_o | output | 3 | New line state |

## Verification
Two events can fall in the same cycle: a retry on the last hit cycle, and the hand-over from the window to the first data beat. The sweep moves the retry position across every window cycle, and includes the last one. After a retry on the last cycle, `drdy_o` and `coh_write` must stay low in the next cycle, exactly as after an earlier retry. A second snoop is also driven on the first window cycle, while the first claim is still being judged, and a retry is pulsed during the transfer. The bench then checks that neither one changes the beat sequence and that neither leaves `hit_o` high afterwards.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [2:0] {
        COH_I = 3'd0,
        COH_S = 3'd1,
        COH_E = 3'd2,
        COH_M = 3'd3,
        COH_R = 3'd4
    } coh_e;

    typedef enum logic [1:0] {
        TT_READ  = 2'd0,
        TT_RWITM = 2'd1,
        TT_WRITE = 2'd2,
        TT_OTHER = 2'd3
    } ttype_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WIN  = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    // bit 0: intervention on (modified), bit 1: exclusive, bit 2: shared responder
    typedef struct packed {
        logic shr;
        logic excl;
        logic on;
    } cls_cfg_t;

    function automatic coh_e after_forward(input logic rwitm);
        return rwitm ? COH_I : COH_S;
    endfunction

endpackage

// File: rtl/snp_elig.sv
module snp_elig
    import snp_pkg::*;
(
    input  logic [1:0] ttype_i,
    input  logic       full_i,
    input  logic       wt_i,
    input  logic       ci_i,
    input  logic [2:0] state_i,
    input  logic [2:0] cfg_i,
    output logic       claim_o,
    output logic       rwitm_o
);
    cls_cfg_t cfg;
    coh_e     st;
    logic     kind_ok;
    logic     attr_ok;
    logic     class_ok;

    assign cfg     = cls_cfg_t'(cfg_i);
    assign st      = coh_e'(state_i);
    assign rwitm_o = (ttype_e'(ttype_i) == TT_RWITM);
    assign kind_ok = (ttype_e'(ttype_i) == TT_READ) || rwitm_o;
    assign attr_ok = full_i && !wt_i && !ci_i;

    always_comb begin
        unique case (st)
            COH_M:   class_ok = cfg.on;
            COH_E:   class_ok = cfg.on && cfg.excl;
            COH_R:   class_ok = cfg.on && cfg.shr;
            default: class_ok = 1'b0;
        endcase
    end

    assign claim_o = kind_ok && attr_ok && class_ok;

    always_comb begin
        if (claim_o) begin
            assert_claim_attr_R3: assert (!wt_i && !ci_i);
        end
    end
endmodule

// File: rtl/snp_beat_seq.sv
module snp_beat_seq #(
    parameter int DW_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [DW_W-1:0] crit_i,
    output logic [DW_W-1:0] dw_o,
    output logic            first_o,
    output logic            last_o
);
    logic [DW_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign dw_o    = crit_i + beat_q;   // wraps modulo the line size
    assign first_o = (beat_q == '0);
    assign last_o  = &beat_q;
endmodule

// File: rtl/snoop_intervene.sv
module snoop_intervene
    import snp_pkg::*;
#(
    parameter int DWA_W     = 29,
    parameter int DATA_W    = 64,
    parameter int TAG_W     = 4,
    parameter int BEATS     = 4,
    parameter int RETRY_LAT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       snp_valid_i,
    input  logic [DWA_W-1:0]           snp_dwaddr_i,
    input  logic [1:0]                 snp_ttype_i,
    input  logic                       snp_full_i,
    input  logic                       snp_wt_i,
    input  logic                       snp_ci_i,
    input  logic [TAG_W-1:0]           snp_tag_i,
    input  logic [2:0]                 lk_state_i,
    input  logic                       lk_in_l2_i,
    input  logic [2:0]                 l1_cfg_i,
    input  logic [2:0]                 l2_cfg_i,
    input  logic                       retry_i,
    output logic                       hit_o,
    output logic                       drdy_o,
    output logic [TAG_W-1:0]           dtag_o,
    output logic [DATA_W-1:0]          dbeat_o,
    output logic [DWA_W-$clog2(BEATS)-1:0] rd_line_o,
    output logic [$clog2(BEATS)-1:0]   rd_dw_o,
    input  logic [DATA_W-1:0]          rd_data_i,
    output logic                       coh_we_o,
    output logic [2:0]                 coh_state_o
);
    localparam int DW_W   = $clog2(BEATS);
    localparam int LINE_W = DWA_W - DW_W;
    localparam int WIN_W  = (RETRY_LAT > 1) ? $clog2(RETRY_LAT) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(RETRY_LAT - 1);

    phase_e            phase_q;
    logic [WIN_W-1:0]  win_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;
    logic [DW_W-1:0]   crit_q;
    logic              rwitm_q;

    logic              claim;
    logic              rwitm;
    logic              beat_first;
    logic              beat_last;
    logic [DW_W-1:0]   beat_dw;

    snp_elig u_elig (
        .ttype_i (snp_ttype_i),
        .full_i  (snp_full_i),
        .wt_i    (snp_wt_i),
        .ci_i    (snp_ci_i),
        .state_i (lk_state_i),
        .cfg_i   (lk_in_l2_i ? l2_cfg_i : l1_cfg_i),
        .claim_o (claim),
        .rwitm_o (rwitm)
    );

    snp_beat_seq #(.DW_W(DW_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load_i  (phase_q != PH_XFER),
        .step_i  (phase_q == PH_XFER),
        .crit_i  (crit_q),
        .dw_o    (beat_dw),
        .first_o (beat_first),
        .last_o  (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            win_q   <= '0;
            tag_q   <= '0;
            line_q  <= '0;
            crit_q  <= '0;
            rwitm_q <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (snp_valid_i && claim) begin
                        phase_q <= PH_WIN;
                        win_q   <= '0;
                        tag_q   <= snp_tag_i;
                        line_q  <= snp_dwaddr_i[DWA_W-1:DW_W];
                        crit_q  <= snp_dwaddr_i[DW_W-1:0];
                        rwitm_q <= rwitm;
                    end
                end
                PH_WIN: begin
                    if (retry_i) begin
                        phase_q <= PH_IDLE;
                    end else if (win_q == WIN_LAST) begin
                        phase_q <= PH_XFER;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                PH_XFER: begin
                    if (beat_last) begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign hit_o       = (phase_q == PH_WIN);
    assign drdy_o      = (phase_q == PH_XFER);
    assign dtag_o      = tag_q;
    assign rd_line_o   = line_q;
    assign rd_dw_o     = beat_dw;
    assign dbeat_o     = drdy_o ? rd_data_i : '0;
    assign coh_we_o    = drdy_o && beat_first;
    assign coh_state_o = coh_we_o ? after_forward(rwitm_q) : COH_I;

    // ---------------- assertions ----------------
    assert_claim_kind_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_o) |-> ($past(snp_ttype_i) == TT_READ || $past(snp_ttype_i) == TT_RWITM));

    assert_claim_full_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_o) |-> ($past(snp_valid_i) && $past(snp_full_i)
                          && !$past(snp_wt_i) && !$past(snp_ci_i)));

    assert_retry_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (hit_o && retry_i) |=> (!hit_o && !drdy_o));

    assert_data_after_window_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_o) |-> ($past(hit_o) && !$past(retry_i)));

    assert_wrap_order_R8: assert property (@(posedge clk) disable iff (rst)
        (drdy_o && $past(drdy_o)) |-> (rd_dw_o == DW_W'($past(rd_dw_o) + 1'b1)));

    assert_update_first_R9: assert property (@(posedge clk) disable iff (rst)
        coh_we_o |-> $rose(drdy_o));

    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_o) |-> !hit_o);
endmodule

// File: tb/snoop_intervene_tb.sv
module snoop_intervene_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  RL         = 2;
    localparam int  DWA_W      = 29;
    localparam int  TAG_W      = 4;
    localparam int  LINE_W     = DWA_W - 2;
    localparam int  MAX_CYC    = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              snp_valid_i = 1'b0;
    logic [DWA_W-1:0]  snp_dwaddr_i = '0;
    logic [1:0]        snp_ttype_i = '0;
    logic              snp_full_i = 1'b0;
    logic              snp_wt_i = 1'b0;
    logic              snp_ci_i = 1'b0;
    logic [TAG_W-1:0]  snp_tag_i = '0;
    logic [2:0]        lk_state_i = '0;
    logic              lk_in_l2_i = 1'b0;
    logic [2:0]        l1_cfg_i = '0;
    logic [2:0]        l2_cfg_i = '0;
    logic              retry_i = 1'b0;
    logic              hit_o, drdy_o, coh_we_o;
    logic [TAG_W-1:0]  dtag_o;
    logic [63:0]       dbeat_o, rd_data_i;
    logic [LINE_W-1:0] rd_line_o;
    logic [1:0]        rd_dw_o;
    logic [2:0]        coh_state_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] mem_word(input logic [LINE_W-1:0] ln, input logic [1:0] dw);
        return 64'hA500_0000_0000_0000 | (64'(ln) << 8) | 64'(dw);
    endfunction

    always_comb rd_data_i = mem_word(rd_line_o, rd_dw_o);

    snoop_intervene #(.DWA_W(DWA_W), .DATA_W(64), .TAG_W(TAG_W), .BEATS(4), .RETRY_LAT(RL)) dut_i (
        .clk(clk), .rst(rst), .snp_valid_i(snp_valid_i), .snp_dwaddr_i(snp_dwaddr_i),
        .snp_ttype_i(snp_ttype_i), .snp_full_i(snp_full_i), .snp_wt_i(snp_wt_i),
        .snp_ci_i(snp_ci_i), .snp_tag_i(snp_tag_i), .lk_state_i(lk_state_i),
        .lk_in_l2_i(lk_in_l2_i), .l1_cfg_i(l1_cfg_i), .l2_cfg_i(l2_cfg_i),
        .retry_i(retry_i), .hit_o(hit_o), .drdy_o(drdy_o), .dtag_o(dtag_o),
        .dbeat_o(dbeat_o), .rd_line_o(rd_line_o), .rd_dw_o(rd_dw_o),
        .rd_data_i(rd_data_i), .coh_we_o(coh_we_o), .coh_state_o(coh_state_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit expect_claim(input int tt, input int full, input int wt, input int ci,
                                        input int st, input logic [2:0] cfg);
        bit cls;
        cls = (st == 3) ? cfg[0] :
              (st == 2) ? (cfg[0] && cfg[1]) :
              (st == 4) ? (cfg[0] && cfg[2]) : 1'b0;
        return (tt < 2) && (full == 1) && (wt == 0) && (ci == 0) && cls;
    endfunction

    task automatic run_txn(input int n, input int tt, input int full, input int wt, input int ci,
                           input int st, input int lvl, input logic [2:0] cfg);
        int          crit;
        int          rpos;
        bit          elig;
        logic [DWA_W-1:0] addr;
        logic [TAG_W-1:0] tag;
        crit = n % 4;
        rpos = (n / 4) % (RL + 1);
        elig = expect_claim(tt, full, wt, ci, st, cfg);
        addr = DWA_W'((n << 2) | crit);
        tag  = TAG_W'(n);
        snp_valid_i  = 1'b1;
        snp_dwaddr_i = addr;
        snp_ttype_i  = 2'(tt);
        snp_full_i   = 1'(full);
        snp_wt_i     = 1'(wt);
        snp_ci_i     = 1'(ci);
        snp_tag_i    = tag;
        lk_state_i   = 3'(st);
        lk_in_l2_i   = 1'(lvl);
        l1_cfg_i     = lvl ? ~cfg : cfg;
        l2_cfg_i     = lvl ? cfg : ~cfg;
        for (int c = 1; c <= RL + 5; c++) begin
            bit alive;
            bit e_hit;
            bit e_drdy;
            int beat;
            string req;
            @(negedge clk);
            alive  = elig && !(rpos != 0 && rpos < c);
            e_hit  = alive && (c <= RL);
            e_drdy = alive && (c > RL) && (c <= RL + 4);
            beat   = c - RL - 1;
            if (c == 1)                       req = "R1/R2/R3/R4";
            else if (elig && rpos != 0 && rpos < c) req = "R6";
            else if (c > RL + 4)              req = "R10";
            else if (c <= RL)                 req = "R5";
            else                              req = "R7";
            chk(req, "hit_o", 64'(hit_o), 64'(e_hit));
            chk(req, "drdy_o", 64'(drdy_o), 64'(e_drdy));
            chk((e_drdy && beat == 0) ? "R9" : "R6", "coh_we_o", 64'(coh_we_o),
                64'(e_drdy && beat == 0));
            if (e_drdy) begin
                logic [1:0] e_dw;
                e_dw = 2'(crit + beat);
                chk("R7", "dtag_o", 64'(dtag_o), 64'(tag));
                chk("R8", "rd_dw_o", 64'(rd_dw_o), 64'(e_dw));
                chk("R8", "rd_line_o", 64'(rd_line_o), 64'(addr >> 2));
                chk("R8", "dbeat_o", dbeat_o, mem_word(LINE_W'(addr >> 2), e_dw));
                if (beat == 0)
                    chk("R9", "coh_state_o", 64'(coh_state_o), (tt == 1) ? 64'd0 : 64'd1);
            end else begin
                chk("R8", "dbeat_o idle", dbeat_o, 64'd0);
            end
            // second snoop on the first window cycle (R10), retry pulses (R6)
            snp_valid_i = (c == 1);
            snp_tag_i   = ~tag;
            retry_i     = (c == rpos) || (c == RL + 2);
        end
        snp_valid_i = 1'b0;
        retry_i     = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "hit_o reset", 64'(hit_o), 64'd0);
        chk("R11", "drdy_o reset", 64'(drdy_o), 64'd0);
        chk("R11", "coh_we_o reset", 64'(coh_we_o), 64'd0);
        chk("R11", "dbeat_o reset", dbeat_o, 64'd0);
        begin
            int n;
            n = 0;
            for (int tt = 0; tt < 4; tt++)
                for (int full = 0; full < 2; full++)
                    for (int wt = 0; wt < 2; wt++)
                        for (int ci = 0; ci < 2; ci++)
                            for (int st = 0; st < 5; st++)
                                for (int lvl = 0; lvl < 2; lvl++)
                                    for (int cfg = 0; cfg < 8; cfg++) begin
                                        run_txn(n, tt, full, wt, ci, st, lvl, 3'(cfg));
                                        n++;
                                    end
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYC && !done) begin
            done = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAX_CYC);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule